// File: doc/BRIEF.md
# Multi-Word Register Load/Store Sequencer

This block moves a run of consecutive general registers to or from memory, one 32-bit word at a time. A command gives the direction, the first register, a base byte address and a byte-order mode. The sequencer starts at the given register and continues up to the highest register, 31. It advances the memory address by one word for each register.

Memory traffic uses a request channel with a valid/ready handshake. A load also waits for a response strobe on a separate channel. The register file is reached through a combinational read port, which supplies store data, and a write port, which takes load data. In little-endian mode the four bytes of every word are reversed on the way through, in both directions.

Only one command runs at a time. While a sequence is running, new commands are dropped. A base address that is not word aligned is rejected with an error pulse, and no memory access takes place.

Top module: `lsm_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `done`, `align_err`, `mem_req_valid` and `rf_we` are all low.
- R2: When idle, an aligned command on `cmd_valid` is taken and `busy` is high from the next cycle until the sequence ends. Commands presented while `busy` is high cause no memory access and change no register.
- R3: A command with start register S performs exactly 32−S word transfers. S = 31 gives a single transfer.
- R4: The first request carries `cmd_base`, and each later request is 4 bytes higher. Transfer k uses register S+k, in ascending order.
- R5: Once `mem_req_valid` is high, it stays high with `mem_req_addr` and `mem_req_wdata` unchanged until a cycle with `mem_req_ready` high.
- R6: For a load, `rf_we` is high only in a cycle where `mem_rsp_valid` is high. No new request is issued until that response arrives. `rf_wr_data` is the response word.
- R7: For a store, `mem_req_write` is 1 and `mem_req_wdata` is the contents of register `rf_rd_idx`. The bench's memory contents then match the registers.
- R8: With `cmd_le` = 1, each word is byte-reversed: bits [7:0] are exchanged with [31:24], and bits [15:8] with [23:16]. With `cmd_le` = 0, words pass unchanged. This applies to both loads and stores.
- R9: `done` is high for exactly one cycle. That cycle follows the final transfer: the accepted store request, or the accepted load response. `busy` is low in that cycle.
- R10: An idle command with `cmd_base[1:0]` ≠ 0 gives a one-cycle `align_err` pulse in the next cycle. It does not raise `busy`, issues no memory request and writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, sampled when idle |
| cmd_store | input | 1 | 1 = store registers to memory, 0 = load |
| cmd_start_idx | input | 5 | First register of the run |
| cmd_base | input | 32 | Byte address of the first word |
| cmd_le | input | 1 | 1 = reverse bytes of every word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| align_err | output | 1 | One-cycle misaligned-base pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_rdata | input | 32 | Read response data |
| rf_rd_idx | output | 5 | Register file read index |
| rf_rd_data | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_wr_idx | output | 5 | Register file write index |
| rf_wr_data | output | 32 | Register file write data |

## Verification
The bench aims at the following cases, each paired with the failure it exposes:

- **Start register 31.** An off-by-one in the end test would stop before the transfer or move a 33rd word past the register file.
- **Stalled ready and delayed responses.** A design that advanced on valid alone would skip addresses or write registers with stale response data.
- **A second command injected mid-sequence.** A design that re-sampled commands while busy would jump to a new base or register and corrupt the expected memory image.
- **Little-endian runs and misaligned bases.** A missing or wrongly ordered byte swap leaves rotated words. A design that did not reject a misaligned base would raise `busy` and touch memory.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_REQ  = 2'd1,
      SEQ_WAIT = 2'd2
   } seq_state_e;
endpackage

// File: rtl/lsm_swap.sv
module lsm_swap #(
   parameter int DW = 32
) (
   input  logic          le,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout
);
   localparam int NB = DW / 8;

   initial begin
      assert (DW % 8 == 0 && DW >= 16)
         else $error("lsm_swap: DW must be a multiple of 8 and at least 16");
   end

   logic [DW-1:0] rev;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign rev[b*8 +: 8] = din[(NB-1-b)*8 +: 8];
   end

   assign dout = le ? rev : din;
endmodule

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
   import lsm_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int IW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cmd_valid,
   input  logic          cmd_store,
   input  logic [IW-1:0] cmd_start,
   input  logic [AW-1:0] cmd_base,
   input  logic          cmd_le,
   output logic          busy,
   output logic          done,
   output logic          align_err,
   output logic          req_valid,
   input  logic          req_ready,
   output logic          req_write,
   output logic [AW-1:0] req_addr,
   input  logic          rsp_valid,
   output logic          rf_we,
   output logic [IW-1:0] idx,
   output logic          le_mode
);
   localparam int            BYTES  = DW / 8;
   localparam int            AB     = $clog2(BYTES);
   localparam logic [AW-1:0] STEP_A = AW'(BYTES);
   localparam logic [IW-1:0] LAST   = {IW{1'b1}};

   initial begin
      assert (AB >= 1 && AW > AB) else $error("lsm_ctrl: bad AW/DW");
   end

   seq_state_e    state_q;
   logic [IW-1:0] idx_q;
   logic [AW-1:0] addr_q;
   logic          store_q, le_q, done_q, aerr_q;
   logic          last, misalign;

   assign last     = (idx_q == LAST);
   assign misalign = |cmd_base[AB-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEQ_IDLE;
         idx_q   <= '0;
         addr_q  <= '0;
         store_q <= 1'b0;
         le_q    <= 1'b0;
         done_q  <= 1'b0;
         aerr_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         aerr_q <= 1'b0;
         case (state_q)
            SEQ_IDLE: begin
               if (cmd_valid) begin
                  if (misalign) begin
                     aerr_q <= 1'b1;
                  end else begin
                     state_q <= SEQ_REQ;
                     idx_q   <= cmd_start;
                     addr_q  <= cmd_base;
                     store_q <= cmd_store;
                     le_q    <= cmd_le;
                  end
               end
            end
            SEQ_REQ: begin
               if (req_ready) begin
                  if (!store_q) begin
                     state_q <= SEQ_WAIT;
                  end else if (last) begin
                     state_q <= SEQ_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     idx_q  <= idx_q + 1'b1;
                     addr_q <= addr_q + STEP_A;
                  end
               end
            end
            SEQ_WAIT: begin
               if (rsp_valid) begin
                  if (last) begin
                     state_q <= SEQ_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     state_q <= SEQ_REQ;
                     idx_q   <= idx_q + 1'b1;
                     addr_q  <= addr_q + STEP_A;
                  end
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != SEQ_IDLE);
   assign done      = done_q;
   assign align_err = aerr_q;
   assign req_valid = (state_q == SEQ_REQ);
   assign req_write = store_q;
   assign req_addr  = addr_q;
   assign rf_we     = (state_q == SEQ_WAIT) && rsp_valid;
   assign idx       = idx_q;
   assign le_mode   = le_q;

   AST_ALIGN_REJECT: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && !busy && misalign) |=> (align_err && !busy && !req_valid)); // R10
   AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      req_valid |-> (req_addr[AB-1:0] == '0)); // R10
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(idx))); // R5
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && req_write && !last) |=>
         (req_valid && req_addr == $past(req_addr) + STEP_A)); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R9
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy); // R9
   AST_WE_ON_RSP: assert property (@(posedge clk) disable iff (rst)
      rf_we |-> (rsp_valid && !req_valid)); // R6
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq #(
   parameter int AW   = 32,
   parameter int DW   = 32,
   parameter int NREG = 32,
   localparam int IW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cmd_valid,
   input  logic          cmd_store,
   input  logic [IW-1:0] cmd_start_idx,
   input  logic [AW-1:0] cmd_base,
   input  logic          cmd_le,
   output logic          busy,
   output logic          done,
   output logic          align_err,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic          mem_req_write,
   output logic [AW-1:0] mem_req_addr,
   output logic [DW-1:0] mem_req_wdata,
   input  logic          mem_rsp_valid,
   input  logic [DW-1:0] mem_rsp_rdata,
   output logic [IW-1:0] rf_rd_idx,
   input  logic [DW-1:0] rf_rd_data,
   output logic          rf_we,
   output logic [IW-1:0] rf_wr_idx,
   output logic [DW-1:0] rf_wr_data
);
   initial begin
      assert (NREG >= 2 && NREG == (1 << IW))
         else $error("lsm_seq: NREG must be a power of two");
   end

   logic [IW-1:0] idx;
   logic          le_mode;

   lsm_ctrl #(.AW(AW), .DW(DW), .IW(IW)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .cmd_valid (cmd_valid),
      .cmd_store (cmd_store),
      .cmd_start (cmd_start_idx),
      .cmd_base  (cmd_base),
      .cmd_le    (cmd_le),
      .busy      (busy),
      .done      (done),
      .align_err (align_err),
      .req_valid (mem_req_valid),
      .req_ready (mem_req_ready),
      .req_write (mem_req_write),
      .req_addr  (mem_req_addr),
      .rsp_valid (mem_rsp_valid),
      .rf_we     (rf_we),
      .idx       (idx),
      .le_mode   (le_mode)
   );

   lsm_swap #(.DW(DW)) u_swap_st (
      .le   (le_mode),
      .din  (rf_rd_data),
      .dout (mem_req_wdata)
   );

   lsm_swap #(.DW(DW)) u_swap_ld (
      .le   (le_mode),
      .din  (mem_rsp_rdata),
      .dout (rf_wr_data)
   );

   assign rf_rd_idx = idx;
   assign rf_wr_idx = idx;
endmodule

// File: tb/lsm_seq_test.sv
module lsm_seq_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_valid = 1'b0, cmd_store = 1'b0, cmd_le = 1'b0;
   logic [4:0]  cmd_start_idx = '0;
   logic [31:0] cmd_base = '0;
   logic        busy, done, align_err;
   logic        mem_req_valid, mem_req_write;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr, mem_req_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_rdata = '0;
   logic [4:0]  rf_rd_idx, rf_wr_idx;
   logic [31:0] rf_rd_data, rf_wr_data;
   logic        rf_we;

   logic [31:0] rf  [32];
   logic [31:0] mem [64];
   int checks = 0, fails = 0, cyc_all = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   assign rf_rd_data = rf[rf_rd_idx];

   lsm_seq uut (.*);

   function automatic logic [31:0] bswap(logic [31:0] x);
      return {x[7:0], x[15:8], x[23:16], x[31:24]};
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory responder
   logic        cap_valid = 0, cap_write = 0, rdy = 0, pend_ld = 0;
   logic [31:0] cap_addr = 0, cap_wdata = 0, pend_addr = 0, exp_addr = 0;
   int          pend_dly = 0, n_hs = 0;

   always @(negedge clk) begin
      if (rst) begin
         cap_valid = 0; rdy = 0; pend_ld = 0;
         mem_req_ready = 0; mem_rsp_valid = 0;
      end else begin
         mem_rsp_valid = 0;
         if (cap_valid && !rdy)
            chk(mem_req_valid && mem_req_addr == cap_addr && mem_req_wdata == cap_wdata,
                "R5 request held", mem_req_addr, cap_addr);
         if (cap_valid && rdy) begin
            chk(cap_addr == exp_addr, "R4 address", cap_addr, exp_addr);
            exp_addr = exp_addr + 4;
            n_hs++;
            if (cap_write) mem[cap_addr[7:2]] = cap_wdata;
            else begin
               pend_ld = 1; pend_dly = $urandom % 3; pend_addr = cap_addr;
            end
         end
         if (pend_ld) begin
            if (pend_dly == 0) begin
               mem_rsp_valid = 1; mem_rsp_rdata = mem[pend_addr[7:2]]; pend_ld = 0;
            end else pend_dly--;
         end
         rdy = ($urandom % 4) != 0;
         mem_req_ready = rdy;
         cap_valid = mem_req_valid; cap_write = mem_req_write;
         cap_addr = mem_req_addr;   cap_wdata = mem_req_wdata;
      end
   end

   // register file write port, sampled mid low phase
   always @(negedge clk) begin
      #2;
      if (!rst && rf_we) begin
         chk(mem_rsp_valid, "R6 write only on response", 32'(rf_we), 32'(mem_rsp_valid));
         rf[rf_wr_idx] = rf_wr_data;
      end
   end

   always @(posedge clk) begin
      cyc_all++;
      if (cyc_all > 150000 && !finished) begin
         finished = 1;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc_all, 150000);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic run_cmd(bit st, int start, logic [31:0] base, bit le, bit poke);
      logic [31:0] rf0 [32];
      logic [31:0] mem0 [64];
      logic [31:0] e;
      int cyc;
      rf0 = rf; mem0 = mem;
      @(negedge clk);
      cmd_valid = 1; cmd_store = st; cmd_start_idx = 5'(start);
      cmd_base = base; cmd_le = le;
      exp_addr = base; n_hs = 0;
      @(negedge clk);
      cmd_valid = 0;
      chk(busy, "R2 busy after accept", 32'(busy), 1);
      cyc = 0;
      while (!done && cyc < 2000) begin
         if (poke && cyc == 1) begin
            cmd_valid = 1; cmd_store = !st; cmd_start_idx = 0;
            cmd_base = 32'h40; cmd_le = !le;
         end else cmd_valid = 0;
         @(negedge clk);
         cyc++;
      end
      cmd_valid = 0;
      chk(done, "R9 done seen", 32'(done), 1);
      chk(!busy, "R9 busy low with done", 32'(busy), 0);
      @(negedge clk);
      chk(!done, "R9 done single cycle", 32'(done), 0);
      chk(n_hs == 32 - start, "R3 transfer count", 32'(n_hs), 32'(32 - start));
      for (int i = 0; i < 32; i++) begin
         e = rf0[i];
         if (!st && i >= start) begin
            e = mem0[base[7:2] + 6'(i - start)];
            if (le) e = bswap(e);
         end
         chk(rf[i] == e, le ? "R8 R6 register (LE)" : "R6 register", rf[i], e);
      end
      for (int a = 0; a < 64; a++) begin
         e = mem0[a];
         if (st && a >= base[7:2] && a < base[7:2] + 32 - start) begin
            e = rf0[start + a - base[7:2]];
            if (le) e = bswap(e);
         end
         chk(mem[a] == e, le ? "R8 R7 memory (LE)" : "R7 memory", mem[a], e);
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 32; i++) rf[i] = $urandom;
      for (int i = 0; i < 64; i++) mem[i] = $urandom;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !align_err && !mem_req_valid && !rf_we, "R1 in reset",
          {27'd0, busy, done, align_err, mem_req_valid, rf_we}, 0);
      rst = 0;
      @(negedge clk);
      chk(!busy && !done && !align_err && !mem_req_valid && !rf_we, "R1 after reset",
          {27'd0, busy, done, align_err, mem_req_valid, rf_we}, 0);

      run_cmd(0, 31, 32'h10, 0, 0);   // R3 single load
      run_cmd(1, 31, 32'h24, 1, 0);   // R3 single store, LE
      run_cmd(0, 0, 32'h00, 1, 0);    // R8 full load LE
      run_cmd(1, 0, 32'h7C, 0, 0);    // R7 full store
      run_cmd(1, 4, 32'h08, 1, 1);    // R2 poke while busy
      run_cmd(0, 10, 32'h30, 0, 1);   // R2 poke while busy

      // R10 misaligned base
      begin
         logic [31:0] mem0 [64];
         logic [31:0] rf0 [32];
         bit ok;
         mem0 = mem; rf0 = rf; n_hs = 0;
         @(negedge clk);
         cmd_valid = 1; cmd_store = 1; cmd_start_idx = 5'd3; cmd_base = 32'h06;
         @(negedge clk);
         cmd_valid = 0;
         chk(align_err, "R10 align_err pulse", 32'(align_err), 1);
         chk(!busy && !mem_req_valid, "R10 no busy/request",
             {30'd0, busy, mem_req_valid}, 0);
         @(negedge clk);
         chk(!align_err, "R10 align_err one cycle", 32'(align_err), 0);
         repeat (3) @(negedge clk);
         ok = (n_hs == 0) && (mem == mem0) && (rf == rf0);
         chk(ok, "R10 no transfer", 32'(n_hs), 0);
      end

      for (int t = 0; t < 24; t++) begin
         int s;
         s = $urandom % 32;
         run_cmd(1'($urandom % 2), s, 32'(($urandom % 32) * 4), 1'($urandom % 2),
                 (s <= 20) && ($urandom % 2 == 1));
      end

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule